// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory. It captures a full external address when a load strobe is seen at a rising clock edge. After that, each clock edge with the advance input asserted steps the burst one beat forward, and only the two least significant address bits change. The bits above the two-bit field stay as they were loaded until the next load.

There are two active-low load strobes. The controller strobe always loads. The processor strobe loads only while the active-low chip enable is asserted. A static order input picks how the low two bits step through the four beats. In linear order they count up modulo four from the loaded start value. In interleaved order they are the start bits XORed with the beat count. For the interleaved default, tie this input high.

Bursts are optional. A new address may be loaded on every cycle at no cost. The outputs are the current word address and the beat position, 0 to 3. The memory array, data path and write decoding sit outside the block.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-low reset drives `addr_out` and `beat` to zero at the next rising edge. This happens even if a strobe or advance is asserted in the same cycle.
- R2: When `strobe_ctl_n` is low at a rising edge, `addr_out` equals `addr_in` and `beat` is 0 after that edge, whatever the value of `chip_en_n`.
- R3: A low `strobe_cpu_n` loads `addr_in` as in R2 only when `chip_en_n` is low. When `chip_en_n` is high, the processor strobe is ignored.
- R4: With no load and `advance_n` low, `beat` increments modulo 4 (3 wraps to 0). The upper address bits `addr_out[ADDR_W-1:2]` change only on a load.
- R5: With no load and `advance_n` high, `addr_out` and `beat` hold their values.
- R6: When `order_lin_n` is 0 (linear), `addr_out[1:0]` equals (start + `beat`) mod 4, where start is the loaded `addr_in[1:0]`.
- R7: When `order_lin_n` is 1 (interleaved), `addr_out[1:0]` equals start XOR `beat`.
- R8: A load in the same cycle as a low `advance_n` takes priority, and `beat` is 0 after the edge.
- R9: Loads on consecutive cycles each take effect at their own edge, with no idle cycle needed between them.
- R10: `order_lin_n` acts combinationally on `addr_out[1:0]`. A change in it shows up without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | ADDR_W | External word address to load |
| strobe_cpu_n | input | 1 | Processor load strobe, active low, gated by chip enable |
| strobe_ctl_n | input | 1 | Controller load strobe, active low, always accepted |
| chip_en_n | input | 1 | Chip enable, active low, qualifies the processor strobe |
| advance_n | input | 1 | Burst advance, active low |
| order_lin_n | input | 1 | Order select: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current word address |
| beat | output | 2 | Beat position within the burst |

## Verification
A wrong beat count or start value appears on `addr_out[1:0]` and `beat` at the first rising edge after the fault. An error in the upper bits appears in the same cycle, even on a cycle where only an advance is requested. A gating fault on the processor strobe shows up one edge after the strobe, as an unexpected reload to `addr_in` while chip enable is high. The most exposed corners are the beat wrap from 3 to 0 in both orders and a load that collides with an advance. Both are driven directly on the ports and checked at the edge that follows.

// File: rtl/bseq_pkg.sv
// Package: shared types and widths for the burst address sequencer.
// Assumes a four-beat burst, which fixes the beat field at two bits.
package bseq_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/bseq_load_ctrl.sv
// Module: bseq_load_ctrl
// Decides whether this cycle loads a new external address.
// Assumes every input is sampled synchronously by the consumer of `load`.
module bseq_load_ctrl (
    input  logic strobe_cpu_n,
    input  logic strobe_ctl_n,
    input  logic chip_en_n,
    output logic load
);
    // Controller strobe always loads; processor strobe needs chip enable.
    always_comb begin
        load = ~strobe_ctl_n | (~strobe_cpu_n & ~chip_en_n);
    end
endmodule

// File: rtl/bseq_beat_ctr.sv
// Module: bseq_beat_ctr
// Holds the loaded start bits and the beat count of the current burst.
// Assumes `load` has priority over `advance_n`; reset is synchronous.
module bseq_beat_ctr
    import bseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance_n,
    input  logic [BEAT_W-1:0] start_in,
    output logic [BEAT_W-1:0] start_q,
    output logic [BEAT_W-1:0] beat_q
);
    // Capture start bits on load, step the beat count on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            beat_q  <= '0;
        end else if (load) begin
            start_q <= start_in;
            beat_q  <= '0;
        end else if (!advance_n) begin
            beat_q  <= beat_q + BEAT_W'(1);
        end
    end
endmodule

// File: rtl/bseq_order_map.sv
// Module: bseq_order_map
// Maps start bits and beat count to the low address bits for the chosen order.
// Assumes the order select is a static strap; it acts combinationally.
module bseq_order_map
    import bseq_pkg::*;
(
    input  burst_order_e      order,
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] low
);
    // Linear adds the beat count, interleaved XORs it with the start bits.
    always_comb begin
        if (order == ORD_LINEAR) begin
            low = start + beat;
        end else begin
            low = start ^ beat;
        end
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Burst address sequencer: loads a word address from either strobe and
// steps the low two bits through a four-beat burst in linear or
// interleaved order. Assumes all control inputs are synchronous to clk.
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_cpu_n,
    input  logic              strobe_ctl_n,
    input  logic              chip_en_n,
    input  logic              advance_n,
    input  logic              order_lin_n,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        beat
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic               load;
    logic [UPPER_W-1:0] upper_q;
    logic [BEAT_W-1:0]  start_q;
    logic [BEAT_W-1:0]  beat_q;
    logic [BEAT_W-1:0]  low_bits;
    burst_order_e       order;

    bseq_load_ctrl u_load (
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .chip_en_n    (chip_en_n),
        .load         (load)
    );

    bseq_beat_ctr u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance_n (advance_n),
        .start_in  (addr_in[BEAT_W-1:0]),
        .start_q   (start_q),
        .beat_q    (beat_q)
    );

    // Order pin decode: low selects linear.
    always_comb begin
        order = order_lin_n ? ORD_INTERLEAVE : ORD_LINEAR;
    end

    bseq_order_map u_map (
        .order (order),
        .start (start_q),
        .beat  (beat_q),
        .low   (low_bits)
    );

    // Upper address register: changes only on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
        end else if (load) begin
            upper_q <= addr_in[ADDR_W-1:BEAT_W];
        end
    end

    // Output assembly.
    always_comb begin
        addr_out = {upper_q, low_bits};
        beat     = beat_q;
    end

    // Assertions
    a_r2_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_ctl_n |=> (beat == 2'd0 && addr_out[ADDR_W-1:BEAT_W] == $past(addr_in[ADDR_W-1:BEAT_W])));

    a_r3_cpu_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_ctl_n && chip_en_n && advance_n) |=> $stable(beat) && $stable(start_q));

    a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_ctl_n && (strobe_cpu_n || chip_en_n)) |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance_n) |=> beat == 2'($past(beat) + 2'd1));

    a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !advance_n) |=> beat == 2'd0);

    a_r7_interleave: assert property (@(posedge clk) disable iff (!rst_n)
        order_lin_n |-> ((addr_out[1:0] ^ start_q) == beat));
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
    localparam int AW = 18;

    typedef struct packed {
        logic          cpu_n;
        logic          ctl_n;
        logic          ce_n;
        logic          adv_n;
        logic          lin_n;
        logic [AW-1:0] a_in;
        logic [AW-1:0] exp_a;
        logic [1:0]    exp_b;
        logic [3:0]    req;
    } vec_t;

    function automatic vec_t mk(logic cpu_n, logic ctl_n, logic ce_n, logic adv_n,
                                logic lin_n, logic [AW-1:0] a_in,
                                logic [AW-1:0] exp_a, logic [1:0] exp_b, logic [3:0] req);
        mk = '{cpu_n, ctl_n, ce_n, adv_n, lin_n, a_in, exp_a, exp_b, req};
    endfunction

    function automatic string req_name(logic [3:0] r);
        case (r)
            4'd1: req_name = "R1";
            4'd2: req_name = "R2";
            4'd3: req_name = "R3";
            4'd4: req_name = "R4";
            4'd5: req_name = "R5";
            4'd6: req_name = "R6";
            4'd7: req_name = "R7";
            4'd8: req_name = "R8";
            4'd9: req_name = "R9";
            default: req_name = "R10";
        endcase
    endfunction

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        mk(1,0,1,1,0, 18'h12345, 18'h12345, 2'd0, 4'd2),  // R2 controller load, ce high
        mk(1,1,0,0,0, 18'h00000, 18'h12346, 2'd1, 4'd6),  // R6 linear step
        mk(1,1,0,0,0, 18'h00000, 18'h12347, 2'd2, 4'd6),
        mk(1,1,0,0,0, 18'h00000, 18'h12344, 2'd3, 4'd4),  // R4 low wraps, upper fixed
        mk(1,1,0,1,0, 18'h3FFFF, 18'h12344, 2'd3, 4'd5),  // R5 hold
        mk(0,1,0,1,1, 18'h0ABC9, 18'h0ABC9, 2'd0, 4'd3),  // R3 cpu load accepted
        mk(1,1,0,0,1, 18'h00000, 18'h0ABC8, 2'd1, 4'd7),  // R7 interleaved
        mk(1,1,0,0,1, 18'h00000, 18'h0ABCB, 2'd2, 4'd7),
        mk(1,1,0,0,1, 18'h00000, 18'h0ABCA, 2'd3, 4'd7),
        mk(1,1,0,0,1, 18'h00000, 18'h0ABC9, 2'd0, 4'd4),  // R4 beat wraps 3->0
        mk(0,1,1,1,1, 18'h3FFFF, 18'h0ABC9, 2'd0, 4'd3),  // R3 cpu ignored
        mk(0,1,1,0,1, 18'h3FFFF, 18'h0ABC8, 2'd1, 4'd3),  // R3 ignored, advance only
        mk(1,0,1,0,1, 18'h3FFFE, 18'h3FFFE, 2'd0, 4'd8),  // R8 load beats advance
        mk(0,1,0,0,1, 18'h00003, 18'h00003, 2'd0, 4'd9),  // R9 back-to-back load
        mk(1,0,0,1,1, 18'h00010, 18'h00010, 2'd0, 4'd9),
        mk(1,1,0,0,0, 18'h00000, 18'h00011, 2'd1, 4'd6),
        mk(1,1,0,0,0, 18'h00000, 18'h00012, 2'd2, 4'd6),
        mk(1,0,1,1,0, 18'h00007, 18'h00007, 2'd0, 4'd2),
        mk(1,1,0,0,0, 18'h00000, 18'h00004, 2'd1, 4'd6)   // R6 start 3 wraps to 0
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_in;
    logic          strobe_cpu_n, strobe_ctl_n, chip_en_n, advance_n, order_lin_n;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_in      (addr_in),
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .chip_en_n    (chip_en_n),
        .advance_n    (advance_n),
        .order_lin_n  (order_lin_n),
        .addr_out     (addr_out),
        .beat         (beat)
    );

    task automatic check(string tag, logic [AW-1:0] ea, logic [1:0] eb);
        checks++;
        if (addr_out !== ea || beat !== eb) begin
            fails++;
            $display("FAIL %s addr=%h beat=%0d expected addr=%h beat=%0d",
                     tag, addr_out, beat, ea, eb);
        end
    endtask

    task automatic drive(logic cpu_n, logic ctl_n, logic ce_n, logic adv_n,
                         logic lin_n, logic [AW-1:0] a);
        @(negedge clk);
        strobe_cpu_n = cpu_n;
        strobe_ctl_n = ctl_n;
        chip_en_n    = ce_n;
        advance_n    = adv_n;
        order_lin_n  = lin_n;
        addr_in      = a;
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0;
        strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; chip_en_n = 1'b1;
        advance_n = 1'b1; order_lin_n = 1'b1; addr_in = '0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset state", 18'h0, 2'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].cpu_n, VEC[i].ctl_n, VEC[i].ce_n, VEC[i].adv_n,
                  VEC[i].lin_n, VEC[i].a_in);
            check(req_name(VEC[i].req), VEC[i].exp_a, VEC[i].exp_b);
        end

        // R10: flip order with no clock edge; start 3, beat 1 -> 3^1 = 2
        @(negedge clk);
        advance_n   = 1'b1;
        order_lin_n = 1'b1;
        #1;
        check("R10 order combinational", 18'h00006, 2'd1);

        // R1: reset wins over a concurrent controller load and advance
        drive(1, 1, 0, 0, 1, 18'h0);
        check("R7 interleaved after flip", 18'h00005, 2'd2);
        @(negedge clk);
        rst_n = 1'b0;
        strobe_ctl_n = 1'b0; advance_n = 1'b0; addr_in = 18'h2AAAA;
        @(posedge clk);
        #1;
        check("R1 reset overrides load", 18'h0, 2'd0);
        @(negedge clk);
        rst_n = 1'b1;
        strobe_ctl_n = 1'b1; advance_n = 1'b1;
        @(posedge clk);
        #1;
        check("R5 hold after reset", 18'h0, 2'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule